// File: doc/BRIEF.md
# Merging Write-Miss Buffer

This block sits beside a data cache that does not allocate lines on a write miss. Every store that misses the cache is handed to this buffer. The core can then move on without waiting for the next memory level. The buffer keeps a small number of entries. Each entry covers one aligned 16-byte block and carries one valid flag per byte. A later miss store to a block that is already buffered is folded into that entry, so it does not take a new slot.

Entries leave through a drain port in the order they were created. Each drain carries the block address, the full 128-bit data word and the byte mask. The oldest entry sits on the drain port the whole time it waits, so it is never modified. A store to that block opens a fresh entry instead. The cache's load pipeline presents load addresses to a hazard output, which reports any buffered block that a load would read stale.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid` and `ld_hazard` are 0 and `st_ready` is 1.
- R2: A store with at least one byte enable allocates a new entry at the tail when no mergeable entry holds its block (block = `st_addr[31:4]`). Byte enable bit k of `st_be` goes to block byte lane 4*`st_addr[3:2]`+k. It carries `st_data[8k+7:8k]` into `dr_data` bits [8*lane+7:8*lane].
- R3: A store whose block matches a valid entry other than the oldest merges into that entry. Enabled bytes overwrite the older bytes in the same lanes, the byte mask becomes the OR of old and new, and no slot is used.
- R4: The oldest entry is never a merge target. A store to its block takes a new entry.
- R5: `dr_valid` is high whenever an entry is held, and `dr_blk`, `dr_data` and `dr_mask` show the oldest entry. The entry leaves on a cycle with `dr_valid` and `dr_ready` high, and entries leave in allocation order. Data bytes never written read as zero.
- R6: When all entries are held and the store cannot merge, `st_ready` is 0 and the store is not taken. `st_ready` returns to 1 in the cycle after an entry drains.
- R7: `ld_hazard` is 1 while `ld_addr[31:4]` equals the block of any held entry. It falls once that entry has drained.
- R8: A store with `st_be` all zero is accepted and changes nothing.
- R9: While `dr_valid` is high and `dr_ready` low, the drain outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Miss store presented |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store taken on this edge when high with st_valid |
| dr_valid | output | 1 | Oldest entry available for drain |
| dr_ready | input | 1 | Next level takes the drain |
| dr_blk | output | 28 | Block address of the drained entry |
| dr_data | output | 128 | Block data |
| dr_mask | output | 16 | Byte valid mask |
| ld_addr | input | 32 | Load address to test |
| ld_hazard | output | 1 | Load block is held in the buffer |

## Verification
`st_ready` and `ld_hazard` are combinational from the inputs and the entry registers. They are due in the same cycle as the stimulus. A store taken at a clock edge shows on the drain port and on the hazard output right after that edge. A drained entry is gone right after the edge that took it. The bench drives inputs just after the falling edge and samples one time step later, still before the next rising edge. Every check therefore sees the state left by exactly the edges counted. Byte-enable and word-position sweeps are compared with a queue model in the bench, which places bytes arithmetically.

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [31:0]       st_data,
  input  logic [3:0]        st_be,
  output logic              st_ready,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [ADDR_W-5:0] dr_blk,
  output logic [127:0]      dr_data,
  output logic [15:0]       dr_mask,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hazard
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = ADDR_W - 4;

  logic [BW-1:0]    blk_q [DEPTH];
  logic [127:0]     dat_q [DEPTH];
  logic [15:0]      msk_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    head_q, tail_q;
  logic [PW:0]      cnt_q;

  logic [DEPTH-1:0] hit_vec, ld_vec;
  logic             hit_any;
  logic [PW-1:0]    hit_idx;
  logic [15:0]      wmask;
  logic [127:0]     wbits, wdata;
  logic             any_be, pop, alloc_en, merge_en;
  logic             unused_bits;

  assign unused_bits = ^{st_addr[1:0], ld_addr[3:0]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (PW'(i) != head_q) && (blk_q[i] == st_addr[ADDR_W-1:4]);
    assign ld_vec[i]  = vld_q[i] && (blk_q[i] == ld_addr[ADDR_W-1:4]);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit_vec[i] && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = PW'(i);
      end
  end

  assign wmask = 16'(st_be) << (4 * st_addr[3:2]);
  for (genvar k = 0; k < 16; k++) begin : g_lane
    assign wbits[8*k +: 8] = {8{wmask[k]}};
    assign wdata[8*k +: 8] = st_data[8*(k%4) +: 8] & wbits[8*k +: 8];
  end

  assign any_be    = |st_be;
  assign st_ready  = !any_be || hit_any || (cnt_q != (PW+1)'(DEPTH));
  assign dr_valid  = cnt_q != '0;
  assign pop       = dr_valid && dr_ready;
  assign alloc_en  = st_valid && st_ready && any_be && !hit_any;
  assign merge_en  = st_valid && st_ready && any_be && hit_any;
  assign dr_blk    = blk_q[head_q];
  assign dr_data   = dat_q[head_q];
  assign dr_mask   = msk_q[head_q];
  assign ld_hazard = |ld_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        blk_q[i] <= '0;
        dat_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_en && tail_q == PW'(i)) begin
          blk_q[i] <= st_addr[ADDR_W-1:4];
          dat_q[i] <= wdata;
          msk_q[i] <= wmask;
          vld_q[i] <= 1'b1;
        end else if (merge_en && hit_idx == PW'(i)) begin
          dat_q[i] <= (dat_q[i] & ~wbits) | wdata;
          msk_q[i] <= msk_q[i] | wmask;
        end
        if (pop && head_q == PW'(i)) vld_q[i] <= 1'b0;
      end
      if (alloc_en) tail_q <= (tail_q == PW'(DEPTH-1)) ? '0 : tail_q + 1'b1;
      if (pop)      head_q <= (head_q == PW'(DEPTH-1)) ? '0 : head_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(alloc_en) - (PW+1)'(pop);
    end
  end

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && any_be && !hit_any && !pop) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  merge_noslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && any_be && hit_any && !pop) |=> cnt_q == $past(cnt_q));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));
  // R7
  empty_nohaz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_valid |-> !ld_hazard);
  // R8
  drain_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> dr_mask != '0);
  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> dr_valid && $stable(dr_blk) && $stable(dr_data) && $stable(dr_mask));
endmodule

// File: tb/test_merge_wbuf.sv
module test_merge_wbuf;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, st_valid, st_ready, dr_valid, dr_ready, ld_hazard;
  logic [31:0] st_addr, st_data, ld_addr;
  logic [3:0] st_be;
  logic [27:0] dr_blk;
  logic [127:0] dr_data;
  logic [15:0] dr_mask;

  merge_wbuf i_merge_wbuf (.clk, .rst_n, .st_valid, .st_addr, .st_data, .st_be, .st_ready,
    .dr_valid, .dr_ready, .dr_blk, .dr_data, .dr_mask, .ld_addr, .ld_hazard);

  int n_chk = 0, n_bad = 0;
  logic [27:0] qa[$];
  logic [127:0] qd[$];
  logic [15:0] qm[$];

  task automatic chk(bit ok, string r, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic model_store(logic [31:0] a, logic [31:0] d, logic [3:0] be);
    logic [15:0] wm;
    int hit;
    if (be == 0) return;
    wm = 16'(be) << (4 * a[3:2]);
    hit = -1;
    for (int i = 1; i < qa.size(); i++) if (hit < 0 && qa[i] == a[31:4]) hit = i;
    if (hit < 0) begin
      qa.push_back(a[31:4]); qd.push_back('0); qm.push_back('0);
      hit = qa.size() - 1;
    end
    for (int k = 0; k < 16; k++)
      if (wm[k]) qd[hit][8*k +: 8] = d[8*(k%4) +: 8];
    qm[hit] = qm[hit] | wm;
  endtask

  task automatic store(logic [31:0] a, logic [31:0] d, logic [3:0] be, string r);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    #1 chk(st_ready === 1'b1, r, 128'(st_ready), 1);
    @(posedge clk);
    model_store(a, d, be);
    #1 st_valid = 0;
  endtask

  task automatic drain_one(string r);
    @(negedge clk);
    #1;
    chk(dr_valid === 1'b1, r, 128'(dr_valid), 1);
    chk(dr_blk === qa[0], r, 128'(dr_blk), 128'(qa[0]));
    chk(dr_data === qd[0], r, dr_data, qd[0]);
    chk(dr_mask === qm[0], r, 128'(dr_mask), 128'(qm[0]));
    dr_ready = 1;
    @(posedge clk);
    void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
    #1 dr_ready = 0;
  endtask

  task automatic drain_all(string r);
    while (qa.size() > 0) drain_one(r);
    @(negedge clk);
    #1 chk(dr_valid === 1'b0, r, 128'(dr_valid), 0);
  endtask

  task automatic haz(logic [31:0] a, bit exp, string r);
    @(negedge clk);
    ld_addr = a;
    #1 chk(ld_hazard === exp, r, 128'(ld_hazard), 128'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] hd;
    rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0; dr_ready = 0; ld_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(dr_valid === 1'b0, "R1", 128'(dr_valid), 0);
    chk(st_ready === 1'b1, "R1", 128'(st_ready), 1);
    chk(ld_hazard === 1'b0, "R1", 128'(ld_hazard), 0);

    // R2 R5 R6 R7: fill, stall, release
    store(32'h100, 32'h11223344, 4'hF, "R2");
    store(32'h204, 32'h55667788, 4'h3, "R2");
    store(32'h308, 32'h99AABBCC, 4'h8, "R2");
    store(32'h40C, 32'hDDEEFF00, 4'hF, "R2");
    haz(32'h10C, 1, "R7");
    haz(32'h404, 1, "R7");
    haz(32'h500, 0, "R7");
    @(negedge clk);
    st_valid = 1; st_addr = 32'h500; st_data = 32'hCAFEF00D; st_be = 4'hF;
    #1 chk(st_ready === 1'b0, "R6", 128'(st_ready), 0);
    @(negedge clk);
    #1 chk(dr_blk === qa[0], "R6", 128'(dr_blk), 128'(qa[0]));
    chk(dr_data === qd[0], "R5", dr_data, qd[0]);
    dr_ready = 1;
    #0 chk(st_ready === 1'b0, "R6", 128'(st_ready), 0);
    @(posedge clk);
    void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
    #1 dr_ready = 0;
    chk(st_ready === 1'b1, "R6", 128'(st_ready), 1);
    @(posedge clk);
    model_store(32'h500, 32'hCAFEF00D, 4'hF);
    #1 st_valid = 0;
    haz(32'h100, 0, "R7");
    haz(32'h508, 1, "R7");
    drain_all("R5");
    haz(32'h500, 0, "R7");

    // R3 R4 R8 R9: merges
    store(32'h1000, 32'hA1A2A3A4, 4'hF, "R2");
    @(negedge clk); #1 hd = dr_data;
    store(32'h2000, 32'h01020304, 4'h3, "R3");
    store(32'h2008, 32'h05060708, 4'hF, "R3");
    store(32'h2000, 32'h0B0C0D0E, 4'h6, "R3");
    store(32'h1004, 32'hB1B2B3B4, 4'hF, "R4");
    store(32'h3000, 32'hDEADBEEF, 4'h0, "R8");
    haz(32'h3000, 0, "R8");
    @(negedge clk); #1 chk(dr_data === hd, "R9", dr_data, hd);
    store(32'h4000, 32'h0F0F0F0F, 4'h1, "R3");
    store(32'h2004, 32'h12345678, 4'hC, "R3");
    @(negedge clk);
    st_valid = 1; st_addr = 32'h5000; st_be = 4'hF;
    #1 chk(st_ready === 1'b0, "R3", 128'(st_ready), 0);
    @(negedge clk); st_valid = 0;
    drain_all("R3");

    // R2 sweep: allocation over every byte-enable and word
    for (int w = 0; w < 4; w++)
      for (int be = 0; be < 16; be++) begin
        store(32'h9000 + 32'(w*4) + 32'(be*16), {8'(be), 8'(w), 8'(be+16), 8'(w+32)}, 4'(be), "R2");
        drain_all("R2");
      end

    // R3 sweep: merge every byte-enable and word into one held block
    store(32'h7000, 32'h77777777, 4'hF, "R4");
    for (int w = 0; w < 4; w++)
      for (int be = 1; be < 16; be++)
        store(32'h8000 + 32'(w*4), {8'(be), 8'(w), 8'(be+64), 8'(w+96)}, 4'(be), "R3");
    drain_all("R3");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule